// File: doc/BRIEF.md
# Rotary and Slider Position Decoder

This block turns the per-pad touch flags of a capacitive ring or strip into motion events. Each valid frame carries one bit per pad that says whether that pad is currently judged as touched. The block reduces the frame to a single finger position at half-pad resolution. It compares that position with the one it holds from the previous touched frame. When the finger has moved, it raises a one-clock event that gives the direction of travel and the distance travelled. The application can then scroll a list in either direction, at a speed that follows the distance.

A parameter selects the pad geometry. In ring mode the last pad sits next to pad 0, so the decoder measures movement around a closed circle and takes the shorter way round. In strip mode the two ends are not adjacent and movement never wraps. Charge measurement, touch thresholds and any acceleration curve are handled outside the block.

Top module: `touch_track_decoder`

## Requirements
- R1: After a synchronous active-low reset, `evt_stb` is 0 and `pos_vld` is 0.
- R2: For a touched frame, position is reported in half-pad units. If the lowest-index touched pad is i, `pos_half` is 2*i. If pad i+1 is also touched, it is 2*i+1. Pads above i+1 do not affect the position.
- R3: In ring mode, a frame with pad 0 and the last pad touched and pad 1 untouched gives position 2*NUM_PADS-1, the midpoint across the joint. In strip mode the same frame gives position 0.
- R4: The outputs update in the clock cycle after a valid frame. `evt_stb` is 1 for exactly that one cycle, and only if the frame had a touch, a reference was held, and the new position differs from the reference.
- R5: `evt_fwd` is 1 when the finger moved toward higher pad indices (forward) and 0 when it moved toward lower indices.
- R6: `evt_steps` gives the size of the movement in half-pad units and is never 0 while `evt_stb` is 1.
- R7: In ring mode, a move from the last pad (position 2*NUM_PADS-2) to pad 0 is reported as forward by 2. The reverse move is reported as backward by 2.
- R8: In ring mode, the direction follows the shorter path around the ring, so `evt_steps` never exceeds NUM_PADS. A move of exactly NUM_PADS half-pads is reported as forward.
- R9: In strip mode, movement never wraps. A move from the last pad to pad 0 is reported as backward by 2*NUM_PADS-2.
- R10: A valid frame with no pad touched clears the tracking state: `pos_vld` goes to 0 and no event is raised. The next touched frame only sets a new reference, with `pos_vld` = 1 and no event.
- R11: Cycles without `frame_vld` are ignored. `evt_stb` is 0, and `pos_vld` and `pos_half` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_vld | input | 1 | Qualifies `pad_hit` for this cycle |
| pad_hit | input | NUM_PADS | Touch flag per pad, bit i for pad i |
| evt_stb | output | 1 | One-cycle motion event |
| evt_fwd | output | 1 | Direction of the last event, 1 = toward higher index |
| evt_steps | output | $clog2(2*NUM_PADS) | Size of the last event in half-pad units |
| pos_vld | output | 1 | A reference position is held |
| pos_half | output | $clog2(2*NUM_PADS) | Current position in half-pad units |

## Verification
The bench drives a ring instance and a strip instance with the same frames. It targets the cases most likely to go wrong.

- The step from the last pad to pad 0. A decoder that ignores the joint reports a long backward move on the ring.
- A jump of more than half the ring. A decoder that never takes the short way reports steps above NUM_PADS.
- A jump of exactly half the ring. A decoder with the wrong tie rule flips the direction.
- The pad-0 and last-pad pair. The ring position must land on the joint midpoint, while the strip instance stays at 0.
- A lift-off followed by a new touch. A decoder that keeps its old reference emits a spurious event.
- Multi-pad frames with a stray high pad. These expose a priority encoder that picks the wrong pad.

// File: rtl/touch_track_pkg.sv
// Shared types for the touch position decoder.
// Assumes nothing beyond a standard SystemVerilog package scope.
package touch_track_pkg;

    // Pad geometry: bounded strip or closed ring.
    typedef enum logic {
        TRACK_STRIP = 1'b0,
        TRACK_RING  = 1'b1
    } track_mode_e;

endpackage

// File: rtl/pad_locator.sv
// Reduces a touch-flag vector to one position in half-pad units.
// The lowest touched pad wins. When its upper neighbour is also touched,
// the position becomes the midpoint between them. In ring mode, pad 0
// together with the last pad (and pad 1 idle) maps onto the joint midpoint.
// Assumes NUM_PADS >= 3. Purely combinational.
module pad_locator
    import touch_track_pkg::*;
#(
    parameter int          NUM_PADS = 8,
    parameter track_mode_e MODE     = TRACK_RING,
    parameter int          POS_W    = $clog2(2 * NUM_PADS)
) (
    input  logic [NUM_PADS-1:0] hits,
    output logic                any_hit,
    output logic [POS_W-1:0]    pos
);

    localparam int JOINT_POS = 2 * NUM_PADS - 1;

    logic [NUM_PADS-1:0] pair_vec;
    logic [POS_W-1:0]    lin_pos;
    logic                joint_pair;

    // Pair flags: pad i and pad i+1 touched together.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_PADS - 1; gi++) begin : g_pair
            assign pair_vec[gi] = hits[gi] & hits[gi+1];
        end
    endgenerate
    assign pair_vec[NUM_PADS-1] = 1'b0;

    // Priority encoder: scanning downward leaves the lowest touched pad.
    always_comb begin
        lin_pos = '0;
        for (int i = NUM_PADS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                lin_pos = POS_W'(2 * i) | POS_W'(pair_vec[i]);
            end
        end
    end

    // Joint detection exists only on a ring.
    generate
        if (MODE == TRACK_RING) begin : g_ring_joint
            assign joint_pair = hits[0] & hits[NUM_PADS-1] & ~hits[1];
        end else begin : g_strip_joint
            assign joint_pair = 1'b0;
        end
    endgenerate

    // Final position select.
    always_comb begin
        any_hit = |hits;
        pos     = joint_pair ? POS_W'(JOINT_POS) : lin_pos;
    end

endmodule

// File: rtl/step_calc.sv
// Computes direction and magnitude between a held reference position
// and a new position, both in half-pad units.
// Ring mode measures modulo 2*NUM_PADS and takes the shorter way; a tie of
// exactly NUM_PADS half-pads counts as forward. Strip mode takes the plain
// difference. Purely combinational.
module step_calc
    import touch_track_pkg::*;
#(
    parameter int          NUM_PADS = 8,
    parameter track_mode_e MODE     = TRACK_RING,
    parameter int          POS_W    = $clog2(2 * NUM_PADS)
) (
    input  logic [POS_W-1:0] old_pos,
    input  logic [POS_W-1:0] new_pos,
    output logic             moved,
    output logic             fwd,
    output logic [POS_W-1:0] mag
);

    localparam int SPAN = 2 * NUM_PADS;

    int raw_diff;

    // Signed difference new minus old.
    always_comb begin
        raw_diff = int'(new_pos) - int'(old_pos);
    end

    generate
        if (MODE == TRACK_RING) begin : g_ring
            int fold;
            // Fold into 0..SPAN-1, then choose the shorter direction.
            always_comb begin
                fold  = (raw_diff < 0) ? raw_diff + SPAN : raw_diff;
                moved = (fold != 0);
                if (fold <= NUM_PADS) begin
                    fwd = 1'b1;
                    mag = POS_W'(fold);
                end else begin
                    fwd = 1'b0;
                    mag = POS_W'(SPAN - fold);
                end
            end
        end else begin : g_strip
            // Plain bounded difference.
            always_comb begin
                moved = (raw_diff != 0);
                if (raw_diff >= 0) begin
                    fwd = 1'b1;
                    mag = POS_W'(raw_diff);
                end else begin
                    fwd = 1'b0;
                    mag = POS_W'(-raw_diff);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/touch_track_decoder.sv
// Top of the touch position decoder. It locates the finger in each valid
// frame, compares the result with the held reference and emits a one-cycle
// motion event carrying the direction and the size in half-pad units.
// An untouched frame drops the reference. The first touch afterwards only
// re-arms it. Assumes pad_hit is already thresholded and synchronous to clk.
module touch_track_decoder
    import touch_track_pkg::*;
#(
    parameter int          NUM_PADS = 8,
    parameter track_mode_e MODE     = TRACK_RING,
    parameter int          POS_W    = $clog2(2 * NUM_PADS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_vld,
    input  logic [NUM_PADS-1:0] pad_hit,
    output logic                evt_stb,
    output logic                evt_fwd,
    output logic [POS_W-1:0]    evt_steps,
    output logic                pos_vld,
    output logic [POS_W-1:0]    pos_half
);

    localparam int SPAN = 2 * NUM_PADS;

    logic             loc_any;
    logic [POS_W-1:0] loc_pos;
    logic             mv_moved;
    logic             mv_fwd;
    logic [POS_W-1:0] mv_mag;

    logic             ref_vld_q;
    logic [POS_W-1:0] ref_pos_q;
    logic             stb_q;
    logic             fwd_q;
    logic [POS_W-1:0] steps_q;

    pad_locator #(
        .NUM_PADS (NUM_PADS),
        .MODE     (MODE),
        .POS_W    (POS_W)
    ) u_loc (
        .hits    (pad_hit),
        .any_hit (loc_any),
        .pos     (loc_pos)
    );

    step_calc #(
        .NUM_PADS (NUM_PADS),
        .MODE     (MODE),
        .POS_W    (POS_W)
    ) u_step (
        .old_pos (ref_pos_q),
        .new_pos (loc_pos),
        .moved   (mv_moved),
        .fwd     (mv_fwd),
        .mag     (mv_mag)
    );

    // Reference tracking: re-arm on touch, drop on an empty frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_vld_q <= 1'b0;
            ref_pos_q <= '0;
        end else if (frame_vld) begin
            ref_vld_q <= loc_any;
            if (loc_any) begin
                ref_pos_q <= loc_pos;
            end
        end
    end

    // Event stage: one-cycle strobe with direction and size latched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            fwd_q   <= 1'b0;
            steps_q <= '0;
        end else begin
            stb_q <= frame_vld & loc_any & ref_vld_q & mv_moved;
            if (frame_vld && loc_any && ref_vld_q && mv_moved) begin
                fwd_q   <= mv_fwd;
                steps_q <= mv_mag;
            end
        end
    end

    // Output mapping.
    always_comb begin
        evt_stb   = stb_q;
        evt_fwd   = fwd_q;
        evt_steps = steps_q;
        pos_vld   = ref_vld_q;
        pos_half  = ref_pos_q;
    end

    // R4: an event only follows a valid frame.
    a_r4_evt_after_frame : assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |-> $past(frame_vld));

    // R6: an event never reports zero movement.
    a_r6_nonzero_steps : assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |-> (evt_steps != '0));

    // R11: idle cycles leave the outputs quiet and the position held.
    a_r11_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> (!evt_stb && $stable(pos_half) && $stable(pos_vld)));

    // R10: an empty frame drops tracking without an event.
    a_r10_clear : assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && pad_hit == '0) |=> (!pos_vld && !evt_stb));

    // R10: a first touch after no reference raises no event.
    a_r10_first_touch : assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !pos_vld) |=> !evt_stb);

    generate
        if (MODE == TRACK_RING) begin : g_ring_chk
            // R8: the shorter way round never exceeds half the ring.
            a_r8_short_way : assert property (@(posedge clk) disable iff (!rst_n)
                evt_stb |-> (int'(evt_steps) <= NUM_PADS));
            // R7: a forward event lands steps ahead of the old reference, modulo the ring.
            a_r7_ring_advance : assert property (@(posedge clk) disable iff (!rst_n)
                (evt_stb && evt_fwd) |->
                    (((int'($past(pos_half)) + int'(evt_steps)) % SPAN) == int'(pos_half)));
        end else begin : g_strip_chk
            // R5: on a strip, forward means the position grew.
            a_r5_strip_dir : assert property (@(posedge clk) disable iff (!rst_n)
                evt_stb |-> (evt_fwd == (pos_half > $past(pos_half))));
        end
    endgenerate

endmodule

// File: tb/sim_touch_track_decoder.sv
// Scoreboard bench: one driver feeds a ring instance (u0) and a strip
// instance (u1), pushes expected results into a queue, and a monitor
// compares them one cycle after each frame.
module sim_touch_track_decoder;
    import touch_track_pkg::*;

    localparam int NP   = 8;
    localparam int PW   = $clog2(2 * NP);
    localparam int SPAN = 2 * NP;

    typedef struct {
        int    m;
        int    due;
        bit    stb;
        bit    fwd;
        int    steps;
        bit    pv;
        int    pos;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_vld = 1'b0;
    logic [NP-1:0] pad_hit = '0;

    logic          stb_r, fwd_r, pv_r, stb_s, fwd_s, pv_s;
    logic [PW-1:0] steps_r, pos_r, steps_s, pos_s;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t q[$];

    int ref_pos[2];
    bit ref_v[2];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    touch_track_decoder #(.NUM_PADS(NP), .MODE(TRACK_RING)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .pad_hit(pad_hit),
        .evt_stb(stb_r), .evt_fwd(fwd_r), .evt_steps(steps_r),
        .pos_vld(pv_r), .pos_half(pos_r));

    touch_track_decoder #(.NUM_PADS(NP), .MODE(TRACK_STRIP)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .pad_hit(pad_hit),
        .evt_stb(stb_s), .evt_fwd(fwd_s), .evt_steps(steps_s),
        .pos_vld(pv_s), .pos_half(pos_s));

    // Reference position rule from R2/R3; -1 when nothing is touched.
    function automatic int locate(input logic [NP-1:0] f, input bit ring);
        for (int i = 0; i < NP; i++) begin
            if (f[i]) begin
                if (ring && i == 0 && f[NP-1] && !f[1]) return SPAN - 1;
                if (i < NP - 1 && f[i+1]) return 2 * i + 1;
                return 2 * i;
            end
        end
        return -1;
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Driver: one valid frame, expectations for both modes.
    task automatic send(input logic [NP-1:0] f, input string tag);
        exp_t e;
        frame_vld = 1'b1;
        pad_hit   = f;
        for (int m = 0; m < 2; m++) begin
            int p;
            p = locate(f, m == 0);
            e.m = m; e.due = cyc + 1; e.tag = tag;
            e.stb = 0; e.fwd = 0; e.steps = 0;
            if (p < 0) begin
                ref_v[m] = 0; e.pv = 0; e.pos = 0;
            end else begin
                if (ref_v[m]) begin
                    int d;
                    d = p - ref_pos[m];
                    if (m == 0) begin
                        if (d < 0) d += SPAN;
                        if (d != 0) begin
                            e.stb = 1;
                            if (d <= NP) begin e.fwd = 1; e.steps = d; end
                            else begin e.fwd = 0; e.steps = SPAN - d; end
                        end
                    end else if (d != 0) begin
                        e.stb = 1; e.fwd = (d > 0); e.steps = (d > 0) ? d : -d;
                    end
                end
                ref_v[m] = 1; ref_pos[m] = p;
                e.pv = 1; e.pos = p;
            end
            q.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
        frame_vld = 1'b0;
    endtask

    // Driver: idle cycles with garbage flags; outputs must hold (R11).
    task automatic idle(input int n);
        exp_t e;
        for (int k = 0; k < n; k++) begin
            pad_hit = NP'(8'h5A ^ k);
            for (int m = 0; m < 2; m++) begin
                e.m = m; e.due = cyc + 1; e.tag = "R11 idle hold";
                e.stb = 0; e.fwd = 0; e.steps = 0;
                e.pv = ref_v[m]; e.pos = ref_pos[m];
                q.push_back(e);
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Monitor: pop items that fall due this cycle and compare.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            bit a_stb, a_fwd, a_pv;
            int a_steps, a_pos;
            bit bad;
            e = q.pop_front();
            a_stb   = (e.m == 0) ? stb_r : stb_s;
            a_fwd   = (e.m == 0) ? fwd_r : fwd_s;
            a_pv    = (e.m == 0) ? pv_r  : pv_s;
            a_steps = (e.m == 0) ? int'(steps_r) : int'(steps_s);
            a_pos   = (e.m == 0) ? int'(pos_r)   : int'(pos_s);
            bad = (a_stb != e.stb) || (a_pv != e.pv) ||
                  (e.pv && a_pos != e.pos) ||
                  (e.stb && (a_fwd != e.fwd || a_steps != e.steps));
            n_run++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s [%s] actual stb=%0d fwd=%0d steps=%0d pv=%0d pos=%0d expected stb=%0d fwd=%0d steps=%0d pv=%0d pos=%0d",
                         e.tag, (e.m == 0) ? "ring" : "strip",
                         a_stb, a_fwd, a_steps, a_pv, a_pos,
                         e.stb, e.fwd, e.steps, e.pv, e.pos);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            summary();
            $finish;
        end
    end

    // Stimulus.
    initial begin
        ref_v[0] = 0; ref_v[1] = 0; ref_pos[0] = 0; ref_pos[1] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state on both instances.
        n_run++;
        if (stb_r || pv_r || stb_s || pv_s) begin
            n_fail++;
            $display("FAIL R1 reset: actual stb=%0d/%0d pv=%0d/%0d expected all 0",
                     stb_r, stb_s, pv_r, pv_s);
        end
        rst_n = 1'b1;
        @(negedge clk);

        send(8'h04, "R10 first touch sets reference");
        send(8'h0C, "R2 R4 R5 R6 pair midpoint forward");
        send(8'h0C, "R4 no movement no event");
        idle(3);
        send(8'h01, "R5 R6 backward move");
        send(8'h80, "R8 R9 to last pad");
        send(8'h01, "R7 R9 last pad to pad 0");
        send(8'h81, "R3 joint pair");
        send(8'h10, "R8 beyond half ring");
        send(8'h01, "R8 tie half ring forward");
        send(8'h00, "R10 empty frame clears");
        idle(2);
        send(8'h20, "R10 re-arm without event");
        send(8'h46, "R2 lowest pad with pair wins");
        send(8'h80, "R7 R9 pad 1 region to last pad");
        send(8'h01, "R7 wrap forward again");
        idle(2);
        while (q.size() > 0) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule